// File: doc/BRIEF.md
# Parallel Converter Host Interface

This block sits between a data converter's sample stream and a host processor. The host reaches it over a 12-bit parallel data bus. The bus is modelled here as separate input, output and output-enable vectors, which a pad ring combines into one bidirectional bus. The block holds two configuration registers and a 16-entry sample FIFO. The converter side pushes samples in through a simple valid/data input. The host pops them with read accesses.

Two select inputs of opposite polarity qualify every access. A configuration bit chooses how the host strobes an access. In the first scheme, one line chooses between read and write. In the second scheme, the same line acts as an active-low write strobe and a separate active-low read strobe is added. Register writes take the register address from the two most significant bus bits.

Two flags report FIFO state. The data-available flag fires once the FIFO fill reaches a programmable trigger level. Its polarity is programmable, and it can be a steady level or a single-cycle pulse. The overflow flag is sticky and records any sample dropped because the FIFO was full.

Top module: `adc_host_if`

## Requirements
- R1: An access takes place only while `cs_n` is 0 and `cs_en` is 1 in the same cycle. With any other combination there is no register write and the bus is not driven.
- R2: `bus_oe` is 1 only during an accepted read access. While it is 1, `bus_out` holds the oldest FIFO sample, with bit 0 as the LSB.
- R3: A write places the register address on bus bits 11:10. The value 00 selects the configuration register: bit 0 selects the separate-strobe scheme, bit 1 makes data-available active high, bit 2 selects pulse mode, and bit 3 clears the FIFO. The value 01 selects the trigger register, whose bits 4:0 hold the trigger level. The values 10 and 11 are ignored.
- R4: In the single-line scheme, `wr_rw`=1 with the block selected is a read and `wr_rw`=0 is a write. `rd_n` has no effect in this scheme.
- R5: In the separate-strobe scheme, a read needs `rd_n`=0 together with `wr_rw`=1. A selected access with `rd_n`=1 and `wr_rw`=1 does not drive the bus. `wr_rw`=0 is a write.
- R6: From reset until the first write to the configuration register, read accesses neither drive the bus nor remove a sample.
- R7: The FIFO holds 16 samples and returns them oldest first. One sample is removed when a read access ends. A read of an empty FIFO shows 0 and removes nothing.
- R8: A sample pushed while the FIFO is full, with no removal in the same cycle, is dropped and sets `ovf`. `ovf` then stays 1 until a reset or a FIFO clear.
- R9: Writing the clear bit empties the FIFO and drops `ovf` at the next clock edge. The clear bit then returns to 0 by itself.
- R10: In level mode, data-available is active while the FIFO fill is at or above the trigger level. It is active-high when the polarity bit is 1 and active-low when it is 0.
- R11: In pulse mode, data-available is active for exactly one cycle after the fill rises to the trigger level, and is inactive otherwise.
- R12: Reset clears the configuration register to 0 (single-line scheme, active-low, level mode) and sets the trigger level to 1. After reset, `data_avail` is 1, `ovf` is 0 and `bus_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low select |
| cs_en | input | 1 | Active-high select |
| wr_rw | input | 1 | Read/write select line, or active-low write strobe in the separate-strobe scheme |
| rd_n | input | 1 | Active-low read strobe (separate-strobe scheme only) |
| bus_in | input | 12 | Bus value from the host; bits 11:10 carry the register address on writes |
| bus_out | output | 12 | Value driven onto the bus during reads |
| bus_oe | output | 1 | Output enable for the bus drivers |
| smp_valid | input | 1 | Sample push strobe |
| smp_data | input | 12 | Sample pushed into the FIFO |
| data_avail | output | 1 | Data-available flag |
| ovf | output | 1 | Sticky FIFO overflow flag |

## Verification
Each internal fault shows at the ports within a cycle or two of where it happens.

- **Configuration register:** a wrong value shows up at the next flag change or read. A flipped polarity inverts `data_avail` at once. A wrong strobe scheme drives the bus on accesses where it should stay quiet.
- **FIFO pointers or count:** these errors show as out-of-order or repeated read data. A missed drop shows as an extra sample after sixteen reads.
- **Overflow flag:** a wrong state of the flag is visible at `ovf` in the cycle after the push that should or should not have set it.

// File: rtl/adc_host_pkg.sv
// Shared types for the converter host interface.
// Assumes a 12-bit bus whose two top bits carry the register address on writes.
package adc_host_pkg;

    localparam int BUS_W = 12;

    // Register address carried on the top two bus bits.
    typedef enum logic [1:0] {
        ADDR_CFG  = 2'b00,
        ADDR_TRIG = 2'b01
    } reg_addr_e;

    // Configuration register fields; the field order matches bits 3..0 of a write.
    typedef struct packed {
        logic fifo_clr;   // bit 3, self-clearing
        logic pulse;      // bit 2
        logic pol_high;   // bit 1
        logic sep;        // bit 0
    } cfg_t;

endpackage

// File: rtl/adc_bus_decode.sv
// Turns select and strobe levels into write-start and read-end events.
// Assumes the strobes are already synchronous to clk.
// A write is taken at the first cycle of a write access.
// A read drives the bus while it is active, and its end pops a sample.
module adc_bus_decode (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic cs_en,
    input  logic wr_rw,
    input  logic rd_n,
    input  logic sep_mode,
    input  logic cfg_ok,
    output logic wr_evt,
    output logic rd_act,
    output logic rd_end
);

    logic sel;
    logic wr_act;
    logic rd_req;
    logic wr_q;
    logic rd_q;

    // Decode the current access from the select and strobe levels.
    always_comb begin
        sel    = !cs_n && cs_en;
        wr_act = sel && !wr_rw;
        rd_req = sel && (sep_mode ? (!rd_n && wr_rw) : wr_rw);
        rd_act = rd_req && cfg_ok;
        wr_evt = wr_act && !wr_q;
        rd_end = rd_q && !rd_act;
    end

    // Remember last cycle's access state for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= 1'b0;
            rd_q <= 1'b0;
        end else begin
            wr_q <= wr_act;
            rd_q <= rd_act;
        end
    end

endmodule

// File: rtl/adc_cfg_regs.sv
// Holds the configuration and trigger registers, written by address.
// Assumes wr_evt lasts one cycle per write.
// Unknown addresses are ignored.
// The FIFO clear bit lives for one cycle only.
module adc_cfg_regs
    import adc_host_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_evt,
    input  logic [1:0]    wr_addr,
    input  logic [CW-1:0] wr_val,
    output cfg_t          cfg,
    output logic [CW-1:0] trig,
    output logic          cfg_ok
);

    // Register update, the self-clearing clear bit and the first-write flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg    <= '0;
            trig   <= CW'(1);
            cfg_ok <= 1'b0;
        end else begin
            cfg.fifo_clr <= 1'b0;
            if (wr_evt) begin
                case (reg_addr_e'(wr_addr))
                    ADDR_CFG: begin
                        cfg    <= cfg_t'(wr_val[3:0]);
                        cfg_ok <= 1'b1;
                    end
                    ADDR_TRIG: trig <= wr_val;
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/adc_sample_fifo.sv
// Sample FIFO with a sticky overflow flag.
// Assumes DEPTH is a power of two.
// A push into a full FIFO, without a pop in the same cycle, is dropped and sets ovf.
// clr empties the FIFO and drops ovf.
module adc_sample_fifo #(
    parameter int DW    = 12,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          ovf
);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] rd_ptr;
    logic [AW-1:0] wr_ptr;
    logic          full;
    logic          empty;
    logic          do_pop;
    logic          do_push;

    // Work out which transfers actually happen this cycle.
    always_comb begin
        full    = (count == CW'(DEPTH));
        empty   = (count == '0);
        do_pop  = pop && !empty;
        do_push = push && (!full || do_pop);
        head    = empty ? '0 : mem[rd_ptr];
    end

    // Storage write, not reset.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // Pointers, fill count and overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
            ovf    <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + AW'(1);
            if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
            count <= count + CW'(do_push) - CW'(do_pop);
            if (push && !do_push) ovf <= 1'b1;
        end
    end

endmodule

// File: rtl/adc_host_if.sv
// Top of the converter host interface.
// It joins bus decode, the registers and the FIFO, and forms the data-available flag.
// The bus is split into in/out/enable; the pad ring builds the tri-state.
module adc_host_if
    import adc_host_pkg::*;
#(
    parameter int DW    = BUS_W,
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          cs_en,
    input  logic          wr_rw,
    input  logic          rd_n,
    input  logic [DW-1:0] bus_in,
    output logic [DW-1:0] bus_out,
    output logic          bus_oe,
    input  logic          smp_valid,
    input  logic [DW-1:0] smp_data,
    output logic          data_avail,
    output logic          ovf
);

    cfg_t          cfg;
    logic [CW-1:0] trig;
    logic          cfg_ok;
    logic          wr_evt;
    logic          rd_act;
    logic          rd_end;
    logic [DW-1:0] fifo_head;
    logic [CW-1:0] fifo_count;
    logic          fifo_clr;
    logic          lvl;
    logic          lvl_q;
    logic          raw;

    assign fifo_clr = cfg.fifo_clr;

    adc_bus_decode u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .cs_en    (cs_en),
        .wr_rw    (wr_rw),
        .rd_n     (rd_n),
        .sep_mode (cfg.sep),
        .cfg_ok   (cfg_ok),
        .wr_evt   (wr_evt),
        .rd_act   (rd_act),
        .rd_end   (rd_end)
    );

    adc_cfg_regs #(.CW(CW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_evt  (wr_evt),
        .wr_addr (bus_in[DW-1:DW-2]),
        .wr_val  (bus_in[CW-1:0]),
        .cfg     (cfg),
        .trig    (trig),
        .cfg_ok  (cfg_ok)
    );

    adc_sample_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (fifo_clr),
        .push      (smp_valid),
        .push_data (smp_data),
        .pop       (rd_end),
        .head      (fifo_head),
        .count     (fifo_count),
        .ovf       (ovf)
    );

    // Bus drive and the data-available flag.
    always_comb begin
        bus_oe     = rd_act;
        bus_out    = rd_act ? fifo_head : '0;
        lvl        = (fifo_count >= trig);
        raw        = cfg.pulse ? (lvl && !lvl_q) : lvl;
        data_avail = cfg.pol_high ? raw : !raw;
    end

    // Previous threshold state, for pulse detection.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl;
    end

endmodule

// File: rtl/adc_host_chk.sv
// Assertion checker for adc_host_if, attached with bind.
// It watches ports and a few internal nets of the top.
module adc_host_chk #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n,
    input logic          cs_en,
    input logic          bus_oe,
    input logic          smp_valid,
    input logic          data_avail,
    input logic          ovf,
    input logic          cfg_ok,
    input logic          fifo_clr,
    input logic          pulse_mode,
    input logic          pol_high,
    input logic [CW-1:0] count
);

    AST_SELECT_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (!cs_n && cs_en));                               // R1
    AST_INIT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ok |-> !bus_oe);                                       // R6
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));                                       // R7
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !fifo_clr) |=> ovf);                                // R8
    AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> $past(smp_valid && count == CW'(DEPTH)));    // R8
    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |=> (count == '0 && !ovf));                        // R9
    AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_mode && pol_high && data_avail) |=> (!data_avail || !pulse_mode || !pol_high)); // R11

endmodule

bind adc_host_if adc_host_chk #(.DEPTH(DEPTH)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .cs_en      (cs_en),
    .bus_oe     (bus_oe),
    .smp_valid  (smp_valid),
    .data_avail (data_avail),
    .ovf        (ovf),
    .cfg_ok     (cfg_ok),
    .fifo_clr   (fifo_clr),
    .pulse_mode (cfg.pulse),
    .pol_high   (cfg.pol_high),
    .count      (fifo_count)
);

// File: tb/adc_host_if_tb.sv
// Self-checking bench for adc_host_if.
module adc_host_if_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cs_n, cs_en, wr_rw, rd_n;
    logic [11:0] bus_in;
    logic [11:0] bus_out;
    logic        bus_oe;
    logic        smp_valid;
    logic [11:0] smp_data;
    logic        data_avail;
    logic        ovf;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = !clk;

    adc_host_if dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cs_en(cs_en), .wr_rw(wr_rw),
        .rd_n(rd_n), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
        .smp_valid(smp_valid), .smp_data(smp_data),
        .data_avail(data_avail), .ovf(ovf)
    );

    // Stimulus table: {pushed sample, expected read value}.
    localparam logic [23:0] VEC [8] = '{
        {12'h001, 12'h001}, {12'hFFE, 12'hFFE}, {12'h800, 12'h800}, {12'h7FF, 12'h7FF},
        {12'hA5A, 12'hA5A}, {12'h3C3, 12'h3C3}, {12'h000, 12'h000}, {12'hFFF, 12'hFFF}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic idle();
        cs_n = 1'b1; cs_en = 1'b0; wr_rw = 1'b1; rd_n = 1'b1; bus_in = '0;
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [9:0] v);
        cs_n = 1'b0; cs_en = 1'b1; wr_rw = 1'b0; bus_in = {a, v};
        step();
        idle();
        step();
    endtask

    // Read access: sep selects the strobe scheme used.
    task automatic read_word(input bit sep, output logic [11:0] d, output logic oe);
        cs_n = 1'b0; cs_en = 1'b1; wr_rw = 1'b1; rd_n = sep ? 1'b0 : 1'b1;
        #1;
        d = bus_out; oe = bus_oe;
        step();
        idle();
        step();
    endtask

    task automatic push(input logic [11:0] v);
        smp_valid = 1'b1; smp_data = v;
        step();
        smp_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [11:0] d;
        logic        oe;
        rst_n = 1'b0; smp_valid = 1'b0; smp_data = '0;
        idle();
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R12 reset state
        chk("R12 data_avail", data_avail, 1);
        chk("R12 ovf", ovf, 0);
        chk("R12 bus_oe", bus_oe, 0);

        // R6: read before first configuration write is ignored
        push(12'h5A5);
        chk("R12 trig default 1, active low", data_avail, 0);
        read_word(1'b0, d, oe);
        chk("R6 no drive before init", oe, 0);
        write_reg(2'b00, 10'h000);
        read_word(1'b0, d, oe);
        chk("R6 sample kept, R2 drive", oe, 1);
        chk("R2 head data", d, 12'h5A5);
        chk("R10 empty inactive", data_avail, 1);
        read_word(1'b0, d, oe);
        chk("R7 empty read value", d, 0);

        // R7 order through the vector table
        for (int i = 0; i < 8; i++) push(VEC[i][23:12]);
        for (int i = 0; i < 8; i++) begin
            read_word(1'b0, d, oe);
            chk("R7 fifo order", d, VEC[i][11:0]);
        end

        // R1: write with cs_en low is ignored
        cs_n = 1'b0; cs_en = 1'b0; wr_rw = 1'b0; bus_in = {2'b01, 10'd3};
        step(); idle(); step();
        push(12'h111);
        chk("R1 unselected write ignored", data_avail, 0);
        write_reg(2'b00, 10'b1000);
        chk("R9 clear empties", data_avail, 1);

        // R3: address 11 ignored
        write_reg(2'b11, 10'b00_0000_0101);
        push(12'h222);
        step();
        chk("R3 bad address ignored", data_avail, 0);
        write_reg(2'b00, 10'b1000);

        // R10 trigger level 3, active low
        write_reg(2'b01, 10'd3);
        push(12'h001); push(12'h002);
        chk("R10 below trigger", data_avail, 1);
        push(12'h003);
        chk("R10 at trigger", data_avail, 0);
        write_reg(2'b00, 10'b1000);

        // R10 active-high polarity
        write_reg(2'b00, 10'b0010);
        chk("R10 high pol empty", data_avail, 0);
        push(12'h001); push(12'h002); push(12'h003);
        chk("R10 high pol at trigger", data_avail, 1);
        write_reg(2'b00, 10'b1010);

        // R11 pulse mode
        write_reg(2'b00, 10'b0110);
        push(12'h001); push(12'h002);
        chk("R11 no pulse below", data_avail, 0);
        push(12'h003);
        chk("R11 pulse on crossing", data_avail, 1);
        step();
        chk("R11 pulse one cycle", data_avail, 0);
        push(12'h004);
        chk("R11 no pulse above", data_avail, 0);
        write_reg(2'b00, 10'b1110);

        // R5 separate strobes
        write_reg(2'b00, 10'b0001);
        push(12'h123);
        cs_n = 1'b0; cs_en = 1'b1; wr_rw = 1'b1; rd_n = 1'b1;
        #1;
        chk("R5 no read without rd_n", bus_oe, 0);
        step(); idle(); step();
        read_word(1'b1, d, oe);
        chk("R5 read with rd_n", oe, 1);
        chk("R5 read data", d, 12'h123);

        // R4 single line: rd_n not needed
        write_reg(2'b00, 10'b0000);
        push(12'h456);
        read_word(1'b0, d, oe);
        chk("R4 read with rd_n high", oe, 1);
        chk("R4 read data", d, 12'h456);

        // R8 overflow
        write_reg(2'b01, 10'd1);
        for (int i = 0; i < 16; i++) push(12'h100 + 12'(i));
        chk("R8 full no ovf", ovf, 0);
        push(12'hFFF);
        chk("R8 ovf set", ovf, 1);
        for (int i = 0; i < 16; i++) begin
            read_word(1'b0, d, oe);
            chk("R8 stored data", d, 12'h100 + 12'(i));
        end
        read_word(1'b0, d, oe);
        chk("R8 overflow sample dropped", d, 0);
        chk("R8 ovf sticky", ovf, 1);
        write_reg(2'b00, 10'b1000);
        chk("R9 clear drops ovf", ovf, 0);

        // R12 reset restores defaults
        write_reg(2'b00, 10'b0010);
        push(12'h777);
        rst_n = 1'b0; step(); step(); rst_n = 1'b1; step();
        chk("R12 reset dav", data_avail, 1);
        read_word(1'b0, d, oe);
        chk("R12 reset needs init", oe, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule